// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block decides which entry of a shared 64-entry table of conversion commands is converted next. Two queues share the table. Queue 1 occupies the entries from 0 up to a split pointer. Queue 2 occupies the entries from the split pointer to the table end. The split pointer is the only boundary. Queue 1 always wins. A queue-1 trigger that arrives while queue 2 is converting aborts that conversion. Queue 2 picks up again once queue 1 has reached its end.

Software sets queue 2 up through one 16-bit control word. The word holds the two interrupt enables, a one-shot arm bit, the operating mode, the resume policy and the split pointer. Queue 2 has three modes. Code 0 is off. Code 1 runs a single scan on a software trigger, provided the arm bit is set. Code 2 runs a continuous scan, with one pass for each rising edge of an external trigger. Every other code acts as off. The converter itself lies outside the block. It returns a one-cycle done pulse, together with the pause bit of the command that has just finished.

Top module: `qsq_top`

## Requirements
- R1: The control word is 16 bits, with these fields: bit 15 completion interrupt enable, bit 14 pause interrupt enable, bit 13 arm (single-scan enable), bits 12:8 mode, bit 7 resume select, bits 6:0 split pointer. A read returns every field as last written, except bit 13, which always reads 0.
- R2: While the completion enable is 1, the done pulse for queue-2 index 63 sets `irq_comp` one cycle later. The flag then stays set until a cycle with `irq_ack[0]` = 1.
- R3: When queue 2 finishes a command whose pause bit is 1, queue 2 halts. If the pause enable is 1, `irq_pause` is also set; it is cleared only by `irq_ack[1]` = 1. The next accepted queue-2 trigger continues at the following index.
- R4: In mode 1 with the arm bit set, a `q2_sw_trig` pulse runs indices pointer..63 in order. The arm bit clears at the end of that pass, so any later software trigger is ignored until software re-arms.
- R5: In mode 2, each rising edge of `q2_ext_trig` starts one pass from the pointer to index 63. Holding the input high does not start another pass.
- R6: A `q1_trig` pulse runs queue 1 over indices 0..pointer-1, or over 0..63 when the pointer is 64 or more. A pointer of 0 makes queue-1 triggers do nothing. A pointer of 64 or more makes queue-2 triggers do nothing.
- R7: A `q1_trig` pulse during a queue-2 conversion aborts that conversion and raises `q2_suspended`. After queue 1 ends, queue 2 continues at one of two places. With the effective resume select 0, it continues at the start of the current subqueue: the pointer, or the index after the last pause. With the effective resume select 1, it continues at the aborted index.
- R8: A write to resume select takes effect only when queue 2 completes index 63 or when the same write changes the mode. A write at any other time is held off.
- R9: A write that changes the mode stops a running queue-2 pass at once.
- R10: `conv_idx`, `conv_busy`, `conv_q2` and the interrupt flags are registered. They change on the clock edge that samples a trigger or a done pulse, and they are stable in every other cycle.
- R11: After reset, the control word reads 0, the sequencer is idle at index 0, and both interrupt flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read value (arm bit reads 0) |
| irq_ack | input | 2 | Write-1-to-clear: bit 0 completion, bit 1 pause |
| q1_trig | input | 1 | Queue-1 trigger pulse |
| q2_sw_trig | input | 1 | Queue-2 software trigger (mode 1) |
| q2_ext_trig | input | 1 | Queue-2 external trigger level (mode 2, rising edge) |
| conv_done | input | 1 | Converter finished the current command |
| ccw_pause | input | 1 | Pause bit of the command just finished |
| conv_busy | output | 1 | A conversion is requested |
| conv_q2 | output | 1 | The requested conversion belongs to queue 2 |
| conv_idx | output | 6 | Table index to convert |
| q2_suspended | output | 1 | Queue 2 is waiting for queue 1 to end |
| irq_comp | output | 1 | Sticky queue-2 completion request |
| irq_pause | output | 1 | Sticky queue-2 pause request |

## Verification
The bench sweeps the split pointer across its edges: 0, 1, 62, 63, 64 and 127. At each value it walks both queues, which catches an off-by-one in the queue-1 end that would leave one entry unconverted or convert one entry twice. It aborts queue 2 under both resume policies, once right after a pause, so a design that mixes up subqueue start and aborted index resumes at the wrong entry. It changes the resume bit in the middle of a pass, which exposes a design that applies the new value at once. It re-triggers after a single scan and holds the external trigger high, so a design that leaves the arm bit set, or that acts on the trigger level rather than the edge, starts a pass it should not.

// File: rtl/qsq_pkg.sv
// Shared constants and types for the dual-queue conversion command sequencer.
// Assumes a 64-entry command table and the fixed 16-bit queue-2 control layout.
package qsq_pkg;
    localparam int TBL_DEPTH = 64;
    localparam int IDX_W     = $clog2(TBL_DEPTH);
    localparam int PTR_W     = IDX_W + 1;
    localparam int CFG_W     = 16;
    localparam int MODE_W    = 5;

    // Field positions inside the control word.
    localparam int B_CIE     = 15;
    localparam int B_PIE     = 14;
    localparam int B_ARM     = 13;
    localparam int B_MODE_LO = 8;
    localparam int B_RES     = 7;

    localparam logic [MODE_W-1:0] MODE_OFF       = 5'd0;
    localparam logic [MODE_W-1:0] MODE_SW_SINGLE = 5'd1;
    localparam logic [MODE_W-1:0] MODE_EXT_CONT  = 5'd2;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TBL_DEPTH - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN1 = 2'd1,
        ST_RUN2 = 2'd2
    } eng_state_e;
endpackage

// File: rtl/qsq_cfg_reg.sv
// Queue-2 control word, single-scan arm bit, effective resume policy and
// the two sticky interrupt flags.
// Assumes event inputs are single-cycle pulses from the sequencing engine.
module qsq_cfg_reg
    import qsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [1:0]          irq_ack,
    input  logic                eoq2_ev,
    input  logic                pause_ev,
    output logic [CFG_W-1:0]    cfg_rdata,
    output logic [MODE_W-1:0]   mode,
    output logic [PTR_W-1:0]    bq2,
    output logic                arm,
    output logic                resume_eff,
    output logic                mode_chg,
    output logic                irq_comp,
    output logic                irq_pause
);
    logic cie_q;
    logic pie_q;
    logic res_q;

    // A write changes the mode when the written mode field differs from the held one.
    always_comb mode_chg = cfg_we && (cfg_wdata[B_MODE_LO +: MODE_W] != mode);

    // Read value: arm bit always reads back as zero.
    always_comb cfg_rdata = {cie_q, pie_q, 1'b0, mode, res_q, bq2};

    // Hold the writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cie_q <= 1'b0;
            pie_q <= 1'b0;
            mode  <= MODE_OFF;
            res_q <= 1'b0;
            bq2   <= '0;
        end else if (cfg_we) begin
            cie_q <= cfg_wdata[B_CIE];
            pie_q <= cfg_wdata[B_PIE];
            mode  <= cfg_wdata[B_MODE_LO +: MODE_W];
            res_q <= cfg_wdata[B_RES];
            bq2   <= cfg_wdata[PTR_W-1:0];
        end
    end

    // Arm bit: set or cleared by writes, cleared when a single scan completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= 1'b0;
        end else if (cfg_we) begin
            arm <= cfg_wdata[B_ARM];
        end else if (eoq2_ev && mode == MODE_SW_SINGLE) begin
            arm <= 1'b0;
        end
    end

    // Effective resume policy: updated only at end of queue 2 or on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_eff <= 1'b0;
        end else if (mode_chg) begin
            resume_eff <= cfg_wdata[B_RES];
        end else if (eoq2_ev) begin
            resume_eff <= res_q;
        end
    end

    // Sticky interrupt flags: setting wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_comp  <= 1'b0;
            irq_pause <= 1'b0;
        end else begin
            if (eoq2_ev && cie_q)      irq_comp <= 1'b1;
            else if (irq_ack[0])       irq_comp <= 1'b0;
            if (pause_ev && pie_q)     irq_pause <= 1'b1;
            else if (irq_ack[1])       irq_pause <= 1'b0;
        end
    end

    AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (eoq2_ev && mode == MODE_SW_SINGLE && !cfg_we) |=> !arm); // R4
    AST_RESUME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoq2_ev && !mode_chg) |=> $stable(resume_eff)); // R8
    AST_COMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_comp && !irq_ack[0]) |=> irq_comp); // R2
    AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pause && !irq_ack[1]) |=> irq_pause); // R3
endmodule

// File: rtl/qsq_trig.sv
// Qualifies the raw trigger inputs into start requests for each queue.
// Assumes q1_trig and q2_sw_trig are pulses; q2_ext_trig is a level whose
// rising edge is detected here.
module qsq_trig
    import qsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic                arm,
    input  logic [PTR_W-1:0]    bq2,
    input  logic                q1_trig,
    input  logic                q2_sw_trig,
    input  logic                q2_ext_trig,
    output logic                q1_go,
    output logic                q2_go
);
    logic ext_prev;
    logic q1_has_room;
    logic q2_has_room;

    // Remember last external trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= q2_ext_trig;
    end

    // Each queue needs at least one table entry to be startable.
    always_comb begin
        q1_has_room = (bq2 != '0);
        q2_has_room = (bq2 < PTR_W'(TBL_DEPTH));
    end

    // Combine mode, arm bit and trigger source into start requests.
    always_comb begin
        q1_go = q1_trig && q1_has_room;
        q2_go = 1'b0;
        if (q2_has_room) begin
            if (mode == MODE_SW_SINGLE)
                q2_go = arm && q2_sw_trig;
            else if (mode == MODE_EXT_CONT)
                q2_go = q2_ext_trig && !ext_prev;
        end
    end

    AST_NO_Q2_WITHOUT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (bq2 >= PTR_W'(TBL_DEPTH)) |-> !q2_go); // R6
endmodule

// File: rtl/qsq_engine.sv
// Sequencing engine: walks the table for queue 1 (0..split-1) and queue 2
// (split..last), handles abort/suspend of queue 2, pauses and subqueues.
// Assumes conv_done is a single-cycle pulse that only comes while busy.
module qsq_engine
    import qsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PTR_W-1:0]    bq2,
    input  logic                resume_eff,
    input  logic                mode_chg,
    input  logic                q1_go,
    input  logic                q2_go,
    input  logic                conv_done,
    input  logic                ccw_pause,
    output logic                eoq2_ev,
    output logic                pause_ev,
    output logic                conv_busy,
    output logic                conv_q2,
    output logic [IDX_W-1:0]    conv_idx,
    output logic                q2_suspended
);
    eng_state_e       st;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sub_start;
    logic [IDX_W-1:0] abort_idx;
    logic             in_pass;
    logic             susp;
    logic [IDX_W-1:0] q1_last;
    logic             run2_done;

    // Last queue-1 index: split minus one, or the table end when split is beyond it.
    always_comb q1_last = (bq2 >= PTR_W'(TBL_DEPTH)) ? IDX_LAST : (bq2[IDX_W-1:0] - 1'b1);

    // A queue-2 completion counts only when neither abort nor mode change takes the cycle.
    always_comb begin
        run2_done = (st == ST_RUN2) && conv_done && !q1_go && !mode_chg;
        eoq2_ev   = run2_done && (idx == IDX_LAST);
        pause_ev  = run2_done && ccw_pause;
    end

    // Main sequencing state, index and queue-2 bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            sub_start <= '0;
            abort_idx <= '0;
            in_pass   <= 1'b0;
            susp      <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (q1_go) begin
                        st  <= ST_RUN1;
                        idx <= '0;
                    end else if (q2_go && !mode_chg) begin
                        st <= ST_RUN2;
                        if (in_pass) begin
                            idx <= sub_start;
                        end else begin
                            in_pass   <= 1'b1;
                            sub_start <= bq2[IDX_W-1:0];
                            idx       <= bq2[IDX_W-1:0];
                        end
                    end
                end
                ST_RUN1: begin
                    if (conv_done) begin
                        if (idx == q1_last) begin
                            if (susp && !mode_chg) begin
                                st   <= ST_RUN2;
                                idx  <= resume_eff ? abort_idx : sub_start;
                                susp <= 1'b0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RUN2: begin
                    if (mode_chg) begin
                        st <= ST_IDLE;
                    end else if (q1_go) begin
                        st        <= ST_RUN1;
                        abort_idx <= idx;
                        susp      <= 1'b1;
                        idx       <= '0;
                    end else if (conv_done) begin
                        if (idx == IDX_LAST) begin
                            st      <= ST_IDLE;
                            in_pass <= 1'b0;
                        end else if (ccw_pause) begin
                            st        <= ST_IDLE;
                            sub_start <= idx + 1'b1;
                            idx       <= idx + 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
            if (mode_chg) begin
                in_pass <= 1'b0;
                susp    <= 1'b0;
            end
        end
    end

    // Registered status toward the ports.
    always_comb begin
        conv_busy    = (st != ST_IDLE);
        conv_q2      = (st == ST_RUN2);
        conv_idx     = idx;
        q2_suspended = susp;
    end

    AST_Q1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN1) |-> (idx <= q1_last)); // R6
    AST_SUSP_ONLY_IN_Q1: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> (st == ST_RUN1)); // R7
    AST_MODE_STOPS_Q2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && st == ST_RUN2) |=> (st != ST_RUN2)); // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !conv_done && !q1_go && !mode_chg) |=> $stable(idx)); // R10
endmodule

// File: rtl/qsq_top.sv
// Top of the dual-queue conversion command sequencer: control word,
// trigger qualification and the sequencing engine.
// Assumes the converter returns one conv_done pulse per requested index.
module qsq_top
    import qsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic [1:0]          irq_ack,
    input  logic                q1_trig,
    input  logic                q2_sw_trig,
    input  logic                q2_ext_trig,
    input  logic                conv_done,
    input  logic                ccw_pause,
    output logic                conv_busy,
    output logic                conv_q2,
    output logic [IDX_W-1:0]    conv_idx,
    output logic                q2_suspended,
    output logic                irq_comp,
    output logic                irq_pause
);
    logic [MODE_W-1:0] mode;
    logic [PTR_W-1:0]  bq2;
    logic              arm;
    logic              resume_eff;
    logic              mode_chg;
    logic              eoq2_ev;
    logic              pause_ev;
    logic              q1_go;
    logic              q2_go;

    qsq_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .irq_ack    (irq_ack),
        .eoq2_ev    (eoq2_ev),
        .pause_ev   (pause_ev),
        .cfg_rdata  (cfg_rdata),
        .mode       (mode),
        .bq2        (bq2),
        .arm        (arm),
        .resume_eff (resume_eff),
        .mode_chg   (mode_chg),
        .irq_comp   (irq_comp),
        .irq_pause  (irq_pause)
    );

    qsq_trig u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .arm         (arm),
        .bq2         (bq2),
        .q1_trig     (q1_trig),
        .q2_sw_trig  (q2_sw_trig),
        .q2_ext_trig (q2_ext_trig),
        .q1_go       (q1_go),
        .q2_go       (q2_go)
    );

    qsq_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .bq2          (bq2),
        .resume_eff   (resume_eff),
        .mode_chg     (mode_chg),
        .q1_go        (q1_go),
        .q2_go        (q2_go),
        .conv_done    (conv_done),
        .ccw_pause    (ccw_pause),
        .eoq2_ev      (eoq2_ev),
        .pause_ev     (pause_ev),
        .conv_busy    (conv_busy),
        .conv_q2      (conv_q2),
        .conv_idx     (conv_idx),
        .q2_suspended (q2_suspended)
    );
endmodule

// File: tb/qsq_top_bench.sv
// Self-checking bench: sweeps split pointers and walks both queues,
// predicting every index arithmetically.
module qsq_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [1:0]  irq_ack = '0;
    logic        q1_trig = 1'b0;
    logic        q2_sw_trig = 1'b0;
    logic        q2_ext_trig = 1'b0;
    logic        conv_done = 1'b0;
    logic        ccw_pause = 1'b0;
    logic        conv_busy;
    logic        conv_q2;
    logic [5:0]  conv_idx;
    logic        q2_suspended;
    logic        irq_comp;
    logic        irq_pause;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qsq_top u_qsq_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_ack(irq_ack), .q1_trig(q1_trig),
        .q2_sw_trig(q2_sw_trig), .q2_ext_trig(q2_ext_trig), .conv_done(conv_done),
        .ccw_pause(ccw_pause), .conv_busy(conv_busy), .conv_q2(conv_q2),
        .conv_idx(conv_idx), .q2_suspended(q2_suspended), .irq_comp(irq_comp),
        .irq_pause(irq_pause)
    );

    function automatic logic [15:0] mk(bit cie, bit pie, bit arm, int mode, bit res, int bq);
        return {cie, pie, arm, 5'(mode), res, 7'(bq)};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack(logic [1:0] m);
        irq_ack = m;
        @(negedge clk);
        irq_ack = '0;
    endtask

    task automatic sw;
        q2_sw_trig = 1'b1;
        @(negedge clk);
        q2_sw_trig = 1'b0;
    endtask

    task automatic ext_pulse;
        q2_ext_trig = 1'b1;
        @(negedge clk);
        q2_ext_trig = 1'b0;
        @(negedge clk);
    endtask

    task automatic q1p;
        q1_trig = 1'b1;
        @(negedge clk);
        q1_trig = 1'b0;
    endtask

    // Check the requested index, then return its done pulse.
    task automatic conv(int exp_idx, bit exp_q2, bit pause, string req);
        chk({req, " busy"}, conv_busy, 1);
        chk({req, " index"}, conv_idx, exp_idx);
        chk({req, " queue"}, conv_q2, exp_q2);
        ccw_pause = pause; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; ccw_pause = 1'b0;
    endtask

    task automatic run_q1(int last, string req);
        for (int i = 0; i <= last; i++) conv(i, 1'b0, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bqs2[6] = '{0, 1, 5, 32, 62, 63};
        int bqs1[5] = '{1, 7, 63, 64, 127};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rdata", cfg_rdata, 0);
        chk("R11 busy", conv_busy, 0);
        chk("R11 idx", conv_idx, 0);
        chk("R11 irq", {irq_comp, irq_pause}, 0);

        // R1 field readback, arm reads zero
        wr(mk(1, 1, 1, 21, 1, 99));
        chk("R1 readback", cfg_rdata, mk(1, 1, 0, 21, 1, 99));
        wr(mk(0, 0, 0, 0, 0, 0));

        // R4/R2 single-scan sweep over split pointers
        foreach (bqs2[k]) begin
            wr(mk(1, 0, 1, 1, 0, bqs2[k]));
            chk("R1 arm reads 0", cfg_rdata, mk(1, 0, 0, 1, 0, bqs2[k]));
            sw();
            for (int i = bqs2[k]; i < 64; i++) conv(i, 1'b1, 1'b0, "R4");
            chk("R4 idle after pass", conv_busy, 0);
            chk("R2 completion irq", irq_comp, 1);
            @(negedge clk);
            chk("R2 irq sticky", irq_comp, 1);
            sw();
            chk("R4 disarmed trigger ignored", conv_busy, 0);
            ack(2'b01);
            chk("R2 irq cleared", irq_comp, 0);
        end
        // R6 pointer 64: queue-2 triggers do nothing
        wr(mk(0, 0, 1, 1, 0, 64));
        sw();
        chk("R6 q2 empty", conv_busy, 0);

        // R6 queue-1 sweep
        wr(mk(0, 0, 0, 0, 0, 0));
        q1p();
        chk("R6 q1 empty", conv_busy, 0);
        foreach (bqs1[k]) begin
            int last;
            last = (bqs1[k] >= 64) ? 63 : bqs1[k] - 1;
            wr(mk(0, 0, 0, 0, 0, bqs1[k]));
            q1p();
            run_q1(last, "R6");
            chk("R6 q1 idle", conv_busy, 0);
        end

        // R3 pause with interrupt
        wr(mk(1, 1, 1, 1, 0, 60));
        sw();
        conv(60, 1'b1, 1'b0, "R3");
        conv(61, 1'b1, 1'b1, "R3");
        chk("R3 halted", conv_busy, 0);
        chk("R3 pause irq", irq_pause, 1);
        chk("R3 no completion", irq_comp, 0);
        sw();
        conv(62, 1'b1, 1'b0, "R3 continue");
        conv(63, 1'b1, 1'b0, "R3 continue");
        chk("R2 completion after pause", irq_comp, 1);
        ack(2'b10);
        chk("R3 pause cleared", {irq_pause, irq_comp}, 2'b01);
        ack(2'b01);

        // R7 suspend, resume select 0 -> split pointer
        wr(mk(0, 0, 0, 2, 0, 8));
        ext_pulse();
        conv(8, 1'b1, 1'b0, "R5");
        conv(9, 1'b1, 1'b0, "R5");
        chk("R7 before abort", conv_idx, 10);
        q1p();
        chk("R7 suspended", q2_suspended, 1);
        run_q1(7, "R7");
        chk("R7 cleared", q2_suspended, 0);
        for (int i = 8; i < 64; i++) conv(i, 1'b1, 1'b0, "R7 resume0");
        chk("R5 idle", conv_busy, 0);

        // R7 resume select 1 -> aborted index; R8 held-off write
        wr(mk(0, 0, 0, 0, 1, 8));
        wr(mk(0, 0, 0, 2, 1, 8));
        ext_pulse();
        conv(8, 1'b1, 1'b0, "R7");
        conv(9, 1'b1, 1'b0, "R7");
        q1p();
        run_q1(7, "R7");
        conv(10, 1'b1, 1'b0, "R7 resume1");
        conv(11, 1'b1, 1'b0, "R7 resume1");
        wr(mk(0, 0, 0, 2, 0, 8));
        q1p();
        run_q1(7, "R8");
        for (int i = 12; i < 64; i++) conv(i, 1'b1, 1'b0, "R8 held");
        ext_pulse();
        conv(8, 1'b1, 1'b0, "R8");
        q1p();
        run_q1(7, "R8");
        for (int i = 8; i < 64; i++) conv(i, 1'b1, 1'b0, "R8 applied");

        // R7 subqueue start after pause
        ext_pulse();
        conv(8, 1'b1, 1'b0, "R7 sub");
        conv(9, 1'b1, 1'b1, "R7 sub");
        chk("R3 paused", conv_busy, 0);
        ext_pulse();
        conv(10, 1'b1, 1'b0, "R7 sub");
        conv(11, 1'b1, 1'b0, "R7 sub");
        q1p();
        run_q1(7, "R7 sub");
        for (int i = 10; i < 64; i++) conv(i, 1'b1, 1'b0, "R7 subqueue resume");

        // R5 level held high does not retrigger
        q2_ext_trig = 1'b1;
        @(negedge clk);
        for (int i = 8; i < 64; i++) conv(i, 1'b1, 1'b0, "R5 level");
        repeat (3) @(negedge clk);
        chk("R5 no retrigger", conv_busy, 0);
        q2_ext_trig = 1'b0;
        @(negedge clk);

        // R10 index holds without done
        ext_pulse();
        repeat (4) @(negedge clk);
        chk("R10 hold", conv_idx, 8);
        conv(8, 1'b1, 1'b0, "R10");
        chk("R10 advance", conv_idx, 9);

        // R9 mode change stops queue 2
        wr(mk(0, 0, 0, 0, 0, 8));
        chk("R9 stopped", conv_busy, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule